// File: doc/BRIEF.md
# Sideband Header Lane Generator

This block attaches a per-word header to a serial bit stream without slowing the stream or inserting extra bits. Each accepted data bit leaves the block paired with one bit of a second lane, so every output symbol is two bits wide, `{lane_bit, data_bit}`. Input and output therefore move at the same symbol rate, and the data lane is passed through bit for bit.

The second lane repeats once every 20 accepted data bits. Its first slot is a 1, used as a start marker. The next five slots carry a 5-bit header, most significant bit first. The remaining 14 slots are zero. The start marker always goes out in the same symbol as the first data bit of a word, so a receiver can find word boundaries by watching the lane. The header is sampled when the first bit of a word is accepted and is held for the rest of that word.

Both edges use valid/ready handshakes. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). A bit is accepted on a clock edge where `in_valid && in_ready` is true. A symbol is handed off on a clock edge where `out_valid && out_ready` is true. A symbol that has not been handed off stays unchanged on the output. The word position counter only advances when a bit is accepted, so gaps in `in_valid` and stalls on `out_ready` do not shift the framing.

Top module: `hdr_lane_gen`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1, and the next accepted bit is word position 0 (its lane bit is 1).
- R2: Bit 0 of `out_sym` is the data bit accepted on the edge that loaded the symbol. No data bit is dropped, duplicated or added, and symbols come out in acceptance order.
- R3: The lane bit (bit 1 of `out_sym`) is 1 for the symbol at word position 0.
- R4: For word positions k = 1 to 5, the lane bit is bit (5 - k) of the captured header, so the header goes out most significant bit first.
- R5: For word positions 6 to 19, the lane bit is 0.
- R6: The word position advances by one per accepted bit and wraps from 19 to 0, so the lane pattern repeats every 20 accepted bits.
- R7: `hdr_in` is captured on the edge where the position-0 bit is accepted. Changes to `hdr_in` at any later position of the same word do not affect the lane bits of that word.
- R8: When a bit is accepted on an edge, `out_valid` is 1 after that edge. When the output is drained and no bit is accepted, `out_valid` is 0 after the edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_sym` holds its value. Cycles with no accepted bit leave the word position unchanged.
- R10: A reset asserted in the middle of a word discards the pending symbol and restarts framing at word position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data bit is offered |
| in_ready | output | 1 | The block can accept a bit this cycle |
| in_bit | input | 1 | Serial data bit |
| hdr_in | input | 5 | Header value, sampled at the start of each word |
| out_valid | output | 1 | `out_sym` holds a symbol |
| out_ready | input | 1 | Downstream takes the symbol this cycle |
| out_sym | output | 2 | Symbol `{lane_bit, data_bit}` |

## Verification
A word position counter that is off by one shows up at the ports within one word. The start marker lands next to the wrong data bit, and the header bits shift into the padding slots. Both are visible on the very next word boundary, at most 20 accepted bits later. A header register that reloads mid-word changes a lane bit in positions 1 to 5 of that same word. A handshake fault appears in the first stalled cycle as a changed held symbol, or as a symbol that is missing or repeated against the ordered expectation queue. Long random runs with gaps on both sides, plus a reset in the middle of a word, expose such faults within a few words.

// File: rtl/hlg_pkg.sv
package hlg_pkg;
  localparam int unsigned WORD_BITS_DEF = 20;
  localparam int unsigned HDR_BITS_DEF  = 5;
  localparam int unsigned SYM_BITS      = 2;
  localparam int unsigned SYM_LANE      = 1;
  localparam int unsigned SYM_DATA      = 0;

  typedef logic [SYM_BITS-1:0] sym_t;

  function automatic sym_t make_sym(input logic lane, input logic data);
    sym_t s;
    s[SYM_LANE] = lane;
    s[SYM_DATA] = data;
    return s;
  endfunction
endpackage

// File: rtl/hlg_period_ctr.sv
module hlg_period_ctr #(
  parameter int unsigned WORD_BITS = 20,
  localparam int unsigned PW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] pos,
  output logic          at_first
);
  localparam logic [PW-1:0] LAST = PW'(WORD_BITS - 1);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (adv) begin
      if (pos_q == LAST) pos_q <= '0;
      else               pos_q <= pos_q + PW'(1);
    end
  end

  assign pos      = pos_q;
  assign at_first = (pos_q == '0);

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && pos_q == LAST) |=> (pos_q == '0)); // R6
  AST_POS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pos_q)); // R9
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST); // R6
endmodule

// File: rtl/hlg_lane_seq.sv
module hlg_lane_seq #(
  parameter int unsigned WORD_BITS = 20,
  parameter int unsigned HDR_BITS  = 5,
  localparam int unsigned PW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic [PW-1:0]       pos,
  input  logic [HDR_BITS-1:0] hdr_in,
  output logic                lane_bit
);
  logic [HDR_BITS-1:0] hdr_q;

  // Capture the header only when the first bit of a word is taken.
  always_ff @(posedge clk) begin
    if (rst)                      hdr_q <= '0;
    else if (adv && pos == '0)    hdr_q <= hdr_in;
  end

  // Slot 0: start marker; slots 1..HDR_BITS: header MSB first; rest: zero.
  always_comb begin
    lane_bit = 1'b0;
    if (pos == '0) lane_bit = 1'b1;
    for (int k = 1; k <= int'(HDR_BITS); k++) begin
      if (pos == PW'(k)) lane_bit = hdr_q[HDR_BITS - k];
    end
  end

  AST_HDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (pos != '0) |=> $stable(hdr_q)); // R7
endmodule

// File: rtl/hlg_out_stage.sv
module hlg_out_stage
  import hlg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  sym_t in_sym,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready,
  output sym_t out_sym
);
  logic v_q;
  sym_t s_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      s_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) s_q <= in_sym;
    end
  end

  assign out_valid = v_q;
  assign out_sym   = s_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym))); // R9
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R8
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R8
endmodule

// File: rtl/hdr_lane_gen.sv
module hdr_lane_gen
  import hlg_pkg::*;
#(
  parameter int unsigned WORD_BITS = WORD_BITS_DEF,
  parameter int unsigned HDR_BITS  = HDR_BITS_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_bit,
  input  logic [HDR_BITS-1:0] hdr_in,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_sym
);
  localparam int unsigned PW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;

  logic          take;
  logic [PW-1:0] pos;
  logic          at_first;
  logic          lane_bit;
  sym_t          sym_next;
  sym_t          sym_q;

  assign take     = in_valid && in_ready;
  assign sym_next = make_sym(lane_bit, in_bit);

  hlg_period_ctr #(.WORD_BITS(WORD_BITS)) u_ctr (
    .clk(clk), .rst(rst), .adv(take), .pos(pos), .at_first(at_first)
  );

  hlg_lane_seq #(.WORD_BITS(WORD_BITS), .HDR_BITS(HDR_BITS)) u_lane (
    .clk(clk), .rst(rst), .adv(take), .pos(pos), .hdr_in(hdr_in),
    .lane_bit(lane_bit)
  );

  hlg_out_stage u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(sym_next),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(sym_q)
  );

  assign out_sym = sym_q;

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    take |=> (out_sym[SYM_DATA] == $past(in_bit))); // R2
  AST_START_MARK: assert property (@(posedge clk) disable iff (rst)
    (take && at_first) |=> out_sym[SYM_LANE]); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (take && pos > PW'(HDR_BITS)) |=> !out_sym[SYM_LANE]); // R5
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready)); // R1
endmodule

// File: tb/tb_hdr_lane_gen.sv
module tb_hdr_lane_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_bit, out_ready;
  logic [4:0] hdr_in;
  logic       in_ready, out_valid;
  logic [1:0] out_sym;

  int total = 0;
  int bad   = 0;
  int m_pos = 0;
  logic [4:0] m_hdr = '0;
  logic [1:0] exp_q[$];
  bit   done = 0;

  always #4 clk = ~clk;

  hdr_lane_gen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .hdr_in(hdr_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_sym(out_sym)
  );

  function automatic logic lane_of(input int p, input logic [4:0] h);
    if (p == 0) return 1'b1;
    if (p <= 5) return h[5 - p];
    return 1'b0;
  endfunction

  function automatic string tag_of(input int p);
    if (p == 0) return "R3 R6";
    if (p <= 5) return "R4 R7";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  string tag_q[$];

  // One cycle: drive at negedge, settle, score, step through the posedge.
  task automatic step(input logic v, input logic b, input logic [4:0] h, input logic r);
    logic acc_in, acc_out, hold;
    logic [1:0] held;
    in_valid = v; in_bit = b; hdr_in = h; out_ready = r;
    #1;
    check("R9 in_ready", in_ready, !out_valid || out_ready);
    acc_out = out_valid && out_ready;
    acc_in  = in_valid && in_ready;
    hold    = out_valid && !out_ready;
    held    = out_sym;
    if (acc_out) begin
      if (exp_q.size() == 0) check("R2 extra symbol", 1, 0);
      else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({"R2 data ", t}, out_sym[0], e[0]);
        check({t, " lane"}, out_sym[1], e[1]);
      end
    end
    if (acc_in) begin
      if (m_pos == 0) m_hdr = h;
      exp_q.push_back({lane_of(m_pos, m_hdr), b});
      tag_q.push_back(tag_of(m_pos));
      m_pos = (m_pos == 19) ? 0 : m_pos + 1;
    end
    @(negedge clk);
    if (acc_in) check("R8 valid after accept", out_valid, 1);
    else if (acc_out) check("R8 empty after drain", out_valid, 0);
    if (hold) check("R9 held symbol", out_sym, held);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 0; out_ready = 0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 out_valid reset", out_valid, 0);
    check("R1 in_ready reset", in_ready, 1);
    exp_q.delete(); tag_q.delete();
    m_pos = 0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 0; in_bit = 0; hdr_in = 0; out_ready = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    do_reset();
    @(negedge clk);
    // R1 R3: first bit after reset is a start marker.
    step(1, 1, 5'b10110, 1);
    check("R1 R3 first lane", out_sym, 2'b11);
    // Full-rate words with a header that changes every cycle (R7).
    for (int i = 0; i < 60; i++) step(1, i[0] ^ i[2], 5'($urandom), 1);
    // Directed stall: hold output several cycles (R9).
    step(1, 1, 5'h1f, 0);
    step(1, 0, 5'h00, 0);
    step(0, 0, 5'h00, 0);
    step(0, 0, 5'h00, 1);
    // Random mix with gaps on both sides (R6 R9).
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 1'($urandom), 5'($urandom), ($urandom % 3) != 0);
    // Mid-word reset (R10).
    for (int i = 0; i < 7; i++) step(1, 1, 5'h15, 1);
    rst = 1'b1; in_valid = 0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 reset drops pending", out_valid, 0);
    exp_q.delete(); tag_q.delete(); m_pos = 0;
    @(negedge clk);
    step(1, 0, 5'h0a, 1);
    check("R10 restart start marker", out_sym, 2'b10);
    for (int i = 0; i < 500; i++)
      step(($urandom % 5) != 0, 1'($urandom), 5'($urandom), ($urandom % 4) != 0);
    // Drain remaining expectations.
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    check("R2 queue drained", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule